// File: doc/BRIEF.md
# Dual-Clock SAR Conversion Sequencer

This block is the digital control of an 8-bit successive-approximation converter inside a microcontroller. Software writes one control word on the bus clock: an enable bit, a conversion-clock source bit and a 4-bit channel code. A write with the enable bit set clears the completion flag and starts one conversion on the chosen input. Software then polls the flag until it reads 1 and reads the result beside it.

The conversion engine runs either from the bus clock or from a free-running internal oscillator that has no phase relation to the bus. On the selected clock it drives the analog input multiplexer and a DAC trial code, and it samples a comparator bit. Each conversion takes a fixed 32 engine cycles. The finished code crosses into the bus domain through a toggle request/acknowledge handshake. A stop input gates the oscillator-driven engine clock without dropping the enable bit, so a conversion that was cut off resumes when stop is released.

Top module: `adc_conv_seq`

## Requirements
- R1: After a bus reset, `done`, `result`, `mux_sel` and `dac_code` all read 0.
- R2: A write (`cfg_wr`=1) with `cfg_enable`=1 clears `done` in the next bus cycle and starts a conversion. The final code is built MSB first: each trial bit is kept when `cmp_in`=1, which means the input is at or above `dac_code`. For a stable input the result therefore equals that input's 8-bit value.
- R3: Channel codes 0–4 (external inputs) and 5–8 (internal references) drive `mux_sel` with the same value. Reserved codes 9–15 drive `mux_sel`=8, the low reference.
- R4: A conversion lasts 32 engine cycles: 4 for sampling, then 8 bit decisions of 3 cycles each from MSB to LSB, then 4 for latching. In bus-clock mode `done` rises 32 to 44 bus cycles after the write.
- R5: `cfg_osc_sel`=1 selects the oscillator as the engine clock and 0 selects the bus clock. The source field is loaded only by a write made while the enable bit reads 0. A write made while the converter is enabled leaves the source unchanged.
- R6: The result crosses with a toggle handshake that has a two-flop synchronizer in each direction. The held data stays stable until the acknowledge returns. `result` and `done` change on the same bus edge, and `result` never changes without a rising `done`.
- R7: A start write during a conversion aborts it. Exactly one flag event follows, and it carries the result of the last channel written.
- R8: A write with `cfg_enable`=0 stops the engine and gates its clock. From then on `done` and `result` keep their values.
- R9: In oscillator mode, `stop_req`=1 gates the engine clock, so `dac_code` freezes and `done` cannot rise. The enable bit stays set, and once stop is released the conversion completes with the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| osc_clk | input | 1 | Free-running internal oscillator clock |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_enable | input | 1 | Enable bit of the written word |
| cfg_osc_sel | input | 1 | Engine clock source of the written word (1 = oscillator) |
| cfg_chan | input | 4 | Channel code of the written word |
| stop_req | input | 1 | Stop-mode request |
| cmp_in | input | 1 | Comparator bit, 1 when the input is at or above the DAC code |
| done | output | 1 | Conversion-complete flag |
| result | output | 8 | Last completed conversion code |
| mux_sel | output | 4 | Analog multiplexer select |
| dac_code | output | 8 | DAC trial code |

## Verification
Some properties are checked on every edge of their own clock. In the bus domain these are the flag clearing after a start write, the flag and result freezing while disabled, the result only changing together with a rising flag, and the source bit holding while enabled. In the engine domain they are the held data staying stable while a request is outstanding, the request toggling only after the last sequence cycle, and the multiplexer select staying within the nine sources. Other behaviour needs whole scenarios driven through the bench's comparator model: the SAR code matching each input value, decoding of the reserved channel codes, the bus-mode latency window, the much longer latency in oscillator mode, the source lock, abort by a rewrite, and freezing and resuming across stop.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_W       = 4;
  localparam int unsigned EXT_INPUTS = 5;
  localparam int unsigned REF_INPUTS = 4;
  localparam int unsigned SRC_COUNT  = EXT_INPUTS + REF_INPUTS;
  localparam logic [CH_W-1:0] REF_LOW_SEL = CH_W'(SRC_COUNT - 1);

  // Reserved codes fall back to the low reference.
  function automatic logic [CH_W-1:0] decode_chan(input logic [CH_W-1:0] code);
    return (code < CH_W'(SRC_COUNT)) ? code : REF_LOW_SEL;
  endfunction
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/adc_clk_gate.sv
module adc_clk_gate (
  input  logic bus_clk,
  input  logic osc_clk,
  input  logic sel_osc,
  input  logic run,
  output logic conv_clk
);
  logic src_clk;
  logic gate_en;

  assign src_clk = sel_osc ? osc_clk : bus_clk;

  // Enable is captured only while the source is low, so no runt pulse.
  always_latch begin
    if (!src_clk) gate_en <= run;
  end

  assign conv_clk = src_clk & gate_en;
endmodule

// File: rtl/adc_bus_regs.sv
module adc_bus_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 8,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned WAKE_CYC   = 4
) (
  input  logic             bus_clk,
  input  logic             bus_rst,
  input  logic             cfg_wr,
  input  logic             cfg_enable,
  input  logic             cfg_osc_sel,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             stop_req,
  input  logic             req_tgl,
  input  logic [RES_W-1:0] res_hold,
  input  logic             tag_hold,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             osc_sel,
  output logic [CH_W-1:0]  chan,
  output logic             start_tgl,
  output logic             ack_tgl,
  output logic             gate_run
);
  logic                en_q, stop_q, req_q, req_s, arrive;
  logic [WAKE_CYC-1:0] wake_sr;

  adc_sync #(.W(1), .DEPTH(SYNC_DEPTH)) u_req_sync (
    .clk(bus_clk), .d(req_tgl), .q(req_s)
  );

  assign arrive = req_s ^ req_q;

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      en_q      <= 1'b0;
      stop_q    <= 1'b0;
      req_q     <= 1'b0;
      osc_sel   <= 1'b0;
      chan      <= '0;
      start_tgl <= 1'b0;
      ack_tgl   <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      wake_sr   <= '1;
      gate_run  <= 1'b1;
    end else begin
      stop_q   <= stop_req;
      req_q    <= req_s;
      wake_sr  <= wake_sr >> 1;
      gate_run <= (en_q | wake_sr[0]) & ~(stop_q & osc_sel);
      if (arrive) ack_tgl <= ~ack_tgl;
      if (cfg_wr) begin
        en_q <= cfg_enable;
        if (!en_q) osc_sel <= cfg_osc_sel;
        if (cfg_enable) begin
          chan      <= cfg_chan;
          start_tgl <= ~start_tgl;
          done      <= 1'b0;
        end
      end
      if (!(cfg_wr && cfg_enable) && arrive && en_q && (tag_hold == start_tgl)) begin
        result <= res_hold;
        done   <= 1'b1;
      end
    end
  end

  AST_WR_CLEARS_DONE: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (cfg_wr && cfg_enable) |=> !done); // R2
  AST_OFF_FLAG_HELD: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (!en_q && !(cfg_wr && cfg_enable)) |=> ($stable(done) && $stable(result))); // R8
  AST_RESULT_WITH_FLAG: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !$stable(result) |-> $rose(done)); // R6
  AST_SRC_LOCKED: assert property (@(posedge bus_clk) disable iff (bus_rst)
    en_q |=> $stable(osc_sel)); // R5
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 8,
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned BIT_CYC    = 3,
  parameter int unsigned LATCH_CYC  = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             conv_clk,
  input  logic             rst_src,
  input  logic             start_tgl,
  input  logic [CH_W-1:0]  chan_cfg,
  input  logic             cmp_in,
  input  logic             ack_tgl,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  output logic             req_tgl,
  output logic [RES_W-1:0] res_hold,
  output logic             tag_hold
);
  localparam int unsigned TOTAL = SAMPLE_CYC + RES_W * BIT_CYC + LATCH_CYC;
  localparam int unsigned CNT_W = $clog2(TOTAL);
  localparam int unsigned SUB_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] BIT_FIRST = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] BIT_END   = CNT_W'(SAMPLE_CYC + RES_W * BIT_CYC);
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(BIT_CYC - 1);

  logic             rst_c, start_s, ack_s, start_q, start_pulse, in_bits;
  logic             busy, tag_run;
  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic [IDX_W-1:0] bidx;

  adc_sync #(.W(3), .DEPTH(SYNC_DEPTH)) u_in_sync (
    .clk(conv_clk),
    .d  ({rst_src, start_tgl, ack_tgl}),
    .q  ({rst_c, start_s, ack_s})
  );

  always_ff @(posedge conv_clk) start_q <= start_s;

  assign start_pulse = start_s ^ start_q;
  assign in_bits     = (cnt >= BIT_FIRST) && (cnt < BIT_END);

  always_ff @(posedge conv_clk) begin
    if (rst_c) begin
      busy     <= 1'b0;
      cnt      <= '0;
      sub      <= '0;
      bidx     <= '0;
      dac_code <= '0;
      mux_sel  <= '0;
      tag_run  <= 1'b0;
      req_tgl  <= 1'b0;
      res_hold <= '0;
      tag_hold <= 1'b0;
    end else if (start_pulse) begin
      busy     <= 1'b1;
      cnt      <= '0;
      sub      <= '0;
      bidx     <= IDX_W'(RES_W - 1);
      dac_code <= '0;
      mux_sel  <= decode_chan(chan_cfg);
      tag_run  <= start_s;
    end else if (busy) begin
      if (cnt < LAST) cnt <= cnt + 1'b1;
      if (in_bits) begin
        if (sub == '0) dac_code[bidx] <= 1'b1;
        if (sub == SUB_LAST) begin
          if (!cmp_in) dac_code[bidx] <= 1'b0;
          sub  <= '0;
          bidx <= bidx - 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
      if ((cnt == LAST) && (req_tgl == ack_s)) begin
        res_hold <= dac_code;
        tag_hold <= tag_run;
        req_tgl  <= ~req_tgl;
        busy     <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge conv_clk) disable iff (rst_c)
    (req_tgl != ack_s) |=> $stable(res_hold)); // R6
  AST_REQ_AT_END: assert property (@(posedge conv_clk) disable iff (rst_c)
    (req_tgl != $past(req_tgl)) |-> ($past(cnt) == LAST && $past(busy))); // R4
  AST_MUX_LEGAL: assert property (@(posedge conv_clk) disable iff (rst_c)
    mux_sel < CH_W'(SRC_COUNT)); // R3
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 8,
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned BIT_CYC    = 3,
  parameter int unsigned LATCH_CYC  = 4,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned WAKE_CYC   = 4
) (
  input  logic             bus_clk,
  input  logic             bus_rst,
  input  logic             osc_clk,
  input  logic             cfg_wr,
  input  logic             cfg_enable,
  input  logic             cfg_osc_sel,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             stop_req,
  input  logic             cmp_in,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code
);
  logic             conv_clk, osc_sel, gate_run;
  logic             start_tgl, ack_tgl, req_tgl, tag_hold;
  logic [CH_W-1:0]  chan;
  logic [RES_W-1:0] res_hold;

  adc_bus_regs #(.RES_W(RES_W), .SYNC_DEPTH(SYNC_DEPTH), .WAKE_CYC(WAKE_CYC)) u_regs (
    .bus_clk    (bus_clk),
    .bus_rst    (bus_rst),
    .cfg_wr     (cfg_wr),
    .cfg_enable (cfg_enable),
    .cfg_osc_sel(cfg_osc_sel),
    .cfg_chan   (cfg_chan),
    .stop_req   (stop_req),
    .req_tgl    (req_tgl),
    .res_hold   (res_hold),
    .tag_hold   (tag_hold),
    .done       (done),
    .result     (result),
    .osc_sel    (osc_sel),
    .chan       (chan),
    .start_tgl  (start_tgl),
    .ack_tgl    (ack_tgl),
    .gate_run   (gate_run)
  );

  adc_clk_gate u_gate (
    .bus_clk (bus_clk),
    .osc_clk (osc_clk),
    .sel_osc (osc_sel),
    .run     (gate_run),
    .conv_clk(conv_clk)
  );

  adc_sar_core #(
    .RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC), .BIT_CYC(BIT_CYC),
    .LATCH_CYC(LATCH_CYC), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_core (
    .conv_clk (conv_clk),
    .rst_src  (bus_rst),
    .start_tgl(start_tgl),
    .chan_cfg (chan),
    .cmp_in   (cmp_in),
    .ack_tgl  (ack_tgl),
    .mux_sel  (mux_sel),
    .dac_code (dac_code),
    .req_tgl  (req_tgl),
    .res_hold (res_hold),
    .tag_hold (tag_hold)
  );
endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  logic       bus_clk = 1'b0, osc_clk = 1'b0, bus_rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_osc_sel = 1'b0, stop_req = 1'b0;
  logic [3:0] cfg_chan = '0;
  logic       cmp_in, done;
  logic [7:0] result, dac_code;
  logic [3:0] mux_sel;
  logic [7:0] ana [16];
  logic [7:0] exp_q [$];
  int         checks = 0, failures = 0;

  always #10 bus_clk = ~bus_clk;   // 50 MHz
  always #330 osc_clk = ~osc_clk;  // unrelated slow oscillator

  // Behavioural comparator: 1 when the selected input is at or above the DAC code.
  assign cmp_in = (ana[mux_sel] >= dac_code);

  adc_conv_seq dut_i (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .osc_clk(osc_clk),
    .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_osc_sel(cfg_osc_sel),
    .cfg_chan(cfg_chan), .stop_req(stop_req), .cmp_in(cmp_in),
    .done(done), .result(result), .mux_sel(mux_sel), .dac_code(dac_code)
  );

  function automatic logic [3:0] exp_sel(input logic [3:0] ch);
    return (ch > 4'd8) ? 4'd8 : ch;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one control write; a start replaces whatever was pending.
  task automatic write_cfg(input bit en, input bit osc, input logic [3:0] ch);
    @(negedge bus_clk);
    cfg_wr = 1'b1; cfg_enable = en; cfg_osc_sel = osc; cfg_chan = ch;
    exp_q.delete();
    if (en) exp_q.push_back(ana[exp_sel(ch)]);
    @(negedge bus_clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_flag(output int lat);
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge bus_clk);
      lat++;
    end
  endtask

  // Monitor: each rising flag pops one expected code.
  initial begin
    logic done_prev;
    logic [7:0] e;
    done_prev = 1'b0;
    forever begin
      @(negedge bus_clk);
      if (!bus_rst && done && !done_prev) begin
        if (exp_q.size() == 0) check(1'b0, "R7", "unexpected flag", result, -1);
        else begin
          e = exp_q.pop_front();
          check(result == e, "R2", "result", result, e);
        end
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    checks++; failures++;
    $display("FAIL watchdog all actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] snap, res_snap;
    ana[0] = 8'h00; ana[1] = 8'hFF; ana[2] = 8'hA5; ana[3] = 8'h5A;
    ana[4] = 8'h01; ana[5] = 8'hF0; ana[6] = 8'h80; ana[7] = 8'h40;
    ana[8] = 8'h03;
    for (int i = 9; i < 16; i++) ana[i] = 8'hEE;

    repeat (10) @(negedge bus_clk);
    bus_rst = 1'b0;
    repeat (10) @(negedge bus_clk);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(result == 8'h00, "R1", "result after reset", result, 0);
    check(mux_sel == 4'd0, "R1", "mux_sel after reset", mux_sel, 0);
    check(dac_code == 8'h00, "R1", "dac_code after reset", dac_code, 0);

    // Bus-clock mode, every source and two reserved codes (R2, R3, R4).
    for (int ch = 0; ch < 11; ch++) begin
      logic [3:0] c;
      c = (ch < 9) ? 4'(ch) : ((ch == 9) ? 4'd9 : 4'd15);
      write_cfg(1'b1, 1'b0, c);
      wait_flag(lat);
      check(lat >= 32 && lat <= 44, "R4", "bus-mode latency", lat, 38);
      check(mux_sel == exp_sel(c), "R3", "mux_sel decode", mux_sel, exp_sel(c));
      repeat (5) @(negedge bus_clk);
    end

    // Source lock: oscillator bit written while enabled is ignored (R5).
    write_cfg(1'b1, 1'b1, 4'd2);
    wait_flag(lat);
    check(lat <= 44, "R5", "source kept while enabled", lat, 44);

    // Enable 0 keeps flag and result (R8).
    res_snap = result;
    write_cfg(1'b0, 1'b0, 4'd0);
    repeat (60) @(negedge bus_clk);
    check(done == 1'b1, "R8", "flag held when disabled", done, 1);
    check(result == res_snap, "R8", "result held when disabled", result, res_snap);

    // Oscillator mode (R5).
    write_cfg(1'b1, 1'b1, 4'd3);
    wait_flag(lat);
    check(lat >= 1000 && lat < 5000, "R5", "oscillator-mode latency", lat, 1056);
    write_cfg(1'b1, 1'b0, 4'd5);
    wait_flag(lat);
    check(lat >= 1000 && lat < 5000, "R5", "source kept while enabled (osc)", lat, 1056);

    // Stop gates the oscillator engine and the conversion resumes (R9).
    write_cfg(1'b1, 1'b1, 4'd6);
    repeat (300) @(negedge bus_clk);
    stop_req = 1'b1;
    repeat (10) @(negedge bus_clk);
    snap = dac_code;
    repeat (2000) @(negedge bus_clk);
    check(done == 1'b0, "R9", "no flag during stop", done, 0);
    check(dac_code == snap, "R9", "dac frozen during stop", dac_code, snap);
    stop_req = 1'b0;
    wait_flag(lat);
    check(done == 1'b1, "R9", "flag after stop release", done, 1);

    // Back to bus clock: disable first, then switch (R5).
    write_cfg(1'b0, 1'b0, 4'd0);
    write_cfg(1'b1, 1'b0, 4'd7);
    wait_flag(lat);
    check(lat <= 44, "R5", "bus clock after switch", lat, 44);

    // Abort by rewrite (R7).
    write_cfg(1'b1, 1'b0, 4'd1);
    repeat (10) @(negedge bus_clk);
    write_cfg(1'b1, 1'b0, 4'd3);
    wait_flag(lat);
    check(result == ana[3], "R7", "result of last channel", result, ana[3]);
    repeat (100) @(negedge bus_clk);
    check(exp_q.size() == 0, "R7", "pending expectations", exp_q.size(), 0);

    // Disable during a conversion: flag stays cleared (R8).
    write_cfg(1'b1, 1'b0, 4'd4);
    repeat (12) @(negedge bus_clk);
    write_cfg(1'b0, 1'b0, 4'd0);
    repeat (200) @(negedge bus_clk);
    check(done == 1'b0, "R8", "no flag after disable", done, 0);
    check(result == ana[3], "R8", "result unchanged after disable", result, ana[3]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule